// File: doc/BRIEF.md
# Clock Stop and Lock Status Monitor

This block supervises a clock generator from the outside. It uses a free-running monitor clock to watch two foreign clocks: the reference clock that feeds the generator and one synthesized clock that the generator produces. Each watched clock drives a toggle flop in its own domain. A two-flop synchronizer carries that toggle into the monitor domain, where a timeout counter checks it. When a clock goes quiet for a set number of monitor cycles, a sticky stop flag is set at a fixed position in an 8-bit status vector. The synthesized clock is checked only while the application reports that it uses that clock.

A small sequencer combines the synchronized lock indication with the stop flags. The clocks-valid output means more than "locked". It is high only after lock has been seen, while lock is still high, and while no stop flag is set. A reset-request output tells the application to reset the generator when a clock has stopped or when lock is lost after it had been gained. Both conditions are latched until the monitor itself is reset.

The sequencer has four states. ACQUIRE is entered at reset and waits for lock. RUNNING means lock is present and no fault has been seen. STOPPED is terminal and is entered from ACQUIRE, RUNNING or UNLOCKED when any stop flag becomes set. UNLOCKED is entered from RUNNING when lock falls, and stays until reset. A stop flag has priority over lock loss.

Top module: `clkmon_top`

## Requirements
- R1: While reset is asserted and just after it is released, status is all zero, clocks_valid is 0 and reset_req is 0.
- R2: Status bit 1 is set once the reference clock has shown no toggle for STOP_TIMEOUT monitor cycles, allowing for the synchronizer delay. The bit stays clear while the reference clock keeps running.
- R3: Status bit 2 is set when the synthesized clock stops while syn_used is 1. While syn_used is 0, bit 2 stays 0 even if that clock is stopped.
- R4: Both stop flags are sticky. A restarted clock does not clear its flag. Only reset does.
- R5: clocks_valid stays 0 until lock_in has been seen high, even when both clocks are running.
- R6: clocks_valid is 1 only while lock is high and both stop flags are clear.
- R7: reset_req is 1 whenever either stop flag is set.
- R8: reset_req rises when lock_in falls after having been high. A lock that was never high does not request a reset.
- R9: Status bits 0 and 3 to 7 always read as zero.
- R10: After a loss of lock, clocks_valid stays 0 and reset_req stays 1 until reset, even if lock_in returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| mon_rst_n | input | 1 | Active-low asynchronous reset for the monitor and the toggle flops |
| ref_clk | input | 1 | Reference clock being watched |
| syn_clk | input | 1 | Synthesized clock being watched |
| syn_used | input | 1 | 1 when the synthesized clock is in use; enables its stop check (monitor domain) |
| lock_in | input | 1 | Lock indication from the generator (asynchronous) |
| status | output | 8 | Bit 1 = reference stopped, bit 2 = synthesized stopped, other bits 0 |
| clocks_valid | output | 1 | Generated clocks may be used |
| reset_req | output | 1 | Generator reset is recommended |

## Verification
The bench builds the monitor with STOP_TIMEOUT = 8 and SYNC_STAGES = 2. With these values every stop condition is reached within a few dozen monitor cycles, so the whole matrix fits in one short run. That matrix covers syn_used on and off, four stop patterns (none, reference, synthesized, both) and three lock histories (never, held, dropped), 24 cases in all. For each case the bench works out the expected flags, valid and reset request arithmetically. It also checks each case a second time after lock returns and the clocks restart, which exercises the sticky behaviour.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
    localparam int STATUS_W     = 8;
    localparam int REF_STOP_BIT = 1;
    localparam int SYN_STOP_BIT = 2;

    typedef enum logic [1:0] {
        ST_ACQUIRE  = 2'd0,
        ST_RUNNING  = 2'd1,
        ST_STOPPED  = 2'd2,
        ST_UNLOCKED = 2'd3
    } mon_state_t;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmon_toggle.sv
module clkmon_toggle (
    input  logic watched_clk,
    input  logic rst_n,
    output logic tgl
);
    always_ff @(posedge watched_clk or negedge rst_n) begin
        if (!rst_n) tgl <= 1'b0;
        else        tgl <= ~tgl;
    end
endmodule

// File: rtl/clkmon_activity.sv
module clkmon_activity #(
    parameter int TIMEOUT     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic tgl_async,
    input  logic arm,
    output logic stopped
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic          tgl_s;
    logic          tgl_prev;
    logic          edge_seen;
    logic [CW-1:0] quiet_cnt;

    clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (mon_clk),
        .rst_n (rst_n),
        .d     (tgl_async),
        .q     (tgl_s)
    );

    assign edge_seen = tgl_s ^ tgl_prev;

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_prev  <= 1'b0;
            quiet_cnt <= '0;
            stopped   <= 1'b0;
        end else begin
            tgl_prev <= tgl_s;
            if (!arm || edge_seen) begin
                quiet_cnt <= '0;
            end else if (quiet_cnt == LAST) begin
                stopped <= 1'b1;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkmon_lock_fsm.sv
module clkmon_lock_fsm
    import clkmon_pkg::*;
(
    input  logic mon_clk,
    input  logic rst_n,
    input  logic lock_s,
    input  logic any_stop,
    output logic clocks_valid,
    output logic reset_req
);
    mon_state_t state_q, state_d;

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACQUIRE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (any_stop)    state_d = ST_STOPPED;
                else if (lock_s) state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                if (any_stop)     state_d = ST_STOPPED;
                else if (!lock_s) state_d = ST_UNLOCKED;
            end
            ST_UNLOCKED: begin
                if (any_stop) state_d = ST_STOPPED;
            end
            ST_STOPPED: state_d = ST_STOPPED;
            default:    state_d = ST_ACQUIRE;
        endcase
    end

    always_comb begin
        clocks_valid = (state_q == ST_RUNNING) && lock_s && !any_stop;
        reset_req    = any_stop || (state_q == ST_UNLOCKED) || (state_q == ST_STOPPED)
                    || ((state_q == ST_RUNNING) && !lock_s);
    end
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
    import clkmon_pkg::*;
#(
    parameter int STOP_TIMEOUT = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                mon_clk,
    input  logic                mon_rst_n,
    input  logic                ref_clk,
    input  logic                syn_clk,
    input  logic                syn_used,
    input  logic                lock_in,
    output logic [STATUS_W-1:0] status,
    output logic                clocks_valid,
    output logic                reset_req
);
    logic ref_tgl, syn_tgl;
    logic ref_stop, syn_stop;
    logic lock_s;

    clkmon_toggle u_ref_tgl (.watched_clk(ref_clk), .rst_n(mon_rst_n), .tgl(ref_tgl));
    clkmon_toggle u_syn_tgl (.watched_clk(syn_clk), .rst_n(mon_rst_n), .tgl(syn_tgl));

    clkmon_activity #(.TIMEOUT(STOP_TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_ref_act (
        .mon_clk   (mon_clk),
        .rst_n     (mon_rst_n),
        .tgl_async (ref_tgl),
        .arm       (1'b1),
        .stopped   (ref_stop)
    );

    clkmon_activity #(.TIMEOUT(STOP_TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_syn_act (
        .mon_clk   (mon_clk),
        .rst_n     (mon_rst_n),
        .tgl_async (syn_tgl),
        .arm       (syn_used),
        .stopped   (syn_stop)
    );

    clkmon_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk   (mon_clk),
        .rst_n (mon_rst_n),
        .d     (lock_in),
        .q     (lock_s)
    );

    clkmon_lock_fsm u_fsm (
        .mon_clk      (mon_clk),
        .rst_n        (mon_rst_n),
        .lock_s       (lock_s),
        .any_stop     (ref_stop | syn_stop),
        .clocks_valid (clocks_valid),
        .reset_req    (reset_req)
    );

    always_comb begin
        status               = '0;
        status[REF_STOP_BIT] = ref_stop;
        status[SYN_STOP_BIT] = syn_stop;
    end
endmodule

// File: rtl/clkmon_top_chk.sv
module clkmon_top_chk (
    input logic       mon_clk,
    input logic       mon_rst_n,
    input logic       syn_used,
    input logic       lock_s,
    input logic [7:0] status,
    input logic       clocks_valid,
    input logic       reset_req
);
    // R4
    ref_flag_sticky_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        status[1] |=> status[1]);

    // R4
    syn_flag_sticky_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        status[2] |=> status[2]);

    // R3
    syn_flag_armed_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        $rose(status[2]) |-> $past(syn_used));

    // R6
    valid_needs_clean_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        clocks_valid |-> (lock_s && !status[1] && !status[2]));

    // R7
    stop_requests_reset_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        (status[1] || status[2]) |-> reset_req);

    // R10
    no_valid_after_loss_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        (clocks_valid && !lock_s) |-> 1'b0);

    // R9
    spare_bits_zero_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        $countones(status & 8'b1111_1001) == 0);
endmodule

bind clkmon_top clkmon_top_chk u_chk (
    .mon_clk      (mon_clk),
    .mon_rst_n    (mon_rst_n),
    .syn_used     (syn_used),
    .lock_s       (lock_s),
    .status       (status),
    .clocks_valid (clocks_valid),
    .reset_req    (reset_req)
);

// File: tb/clkmon_top_test.sv
`timescale 1ns/1ps
module clkmon_top_test;
    localparam int T = 8;

    logic       mon_clk = 1'b0;
    logic       mon_rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       syn_clk = 1'b0;
    logic       ref_en = 1'b1;
    logic       syn_en = 1'b1;
    logic       syn_used = 1'b0;
    logic       lock_in = 1'b0;
    logic [7:0] status;
    logic       clocks_valid;
    logic       reset_req;

    int checks = 0;
    int fails  = 0;

    clkmon_top #(.STOP_TIMEOUT(T), .SYNC_STAGES(2)) uut (
        .mon_clk      (mon_clk),
        .mon_rst_n    (mon_rst_n),
        .ref_clk      (ref_clk),
        .syn_clk      (syn_clk),
        .syn_used     (syn_used),
        .lock_in      (lock_in),
        .status       (status),
        .clocks_valid (clocks_valid),
        .reset_req    (reset_req)
    );

    always #4 mon_clk = ~mon_clk;
    always begin #11; if (ref_en) ref_clk = ~ref_clk; end
    always begin #5;  if (syn_en) syn_clk = ~syn_clk; end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge mon_clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        for (int su = 0; su < 2; su++) begin
            for (int sp = 0; sp < 4; sp++) begin
                for (int lp = 0; lp < 3; lp++) begin
                    int exp_ref, exp_syn, exp_valid, exp_rr;
                    exp_ref   = sp[0];
                    exp_syn   = sp[1] & su;
                    exp_valid = (lp == 1 && exp_ref == 0 && exp_syn == 0) ? 1 : 0;
                    exp_rr    = (exp_ref == 1 || exp_syn == 1 || lp == 2) ? 1 : 0;

                    ref_en = 1'b1; syn_en = 1'b1; lock_in = 1'b0; syn_used = su[0];
                    mon_rst_n = 1'b0;
                    wait_cyc(4);
                    chk("R1 status in reset", int'(status), 0);
                    chk("R1 valid in reset", int'(clocks_valid), 0);
                    chk("R1 reset_req in reset", int'(reset_req), 0);
                    mon_rst_n = 1'b1;
                    wait_cyc(40);
                    chk("R2 no stop while running", int'(status), 0);
                    chk("R5 valid before lock", int'(clocks_valid), 0);
                    chk("R8 no request without lock", int'(reset_req), 0);

                    if (lp >= 1) begin
                        lock_in = 1'b1;
                        wait_cyc(10);
                        chk("R6 valid with lock", int'(clocks_valid), 1);
                    end
                    if (lp == 2) begin
                        lock_in = 1'b0;
                        wait_cyc(10);
                        chk("R8 request after lock loss", int'(reset_req), 1);
                        chk("R6 valid after lock loss", int'(clocks_valid), 0);
                    end

                    ref_en = ~sp[0];
                    syn_en = ~sp[1];
                    wait_cyc(T / 2);
                    chk("R2 no early ref flag", int'(status[1]), 0);
                    chk("R3 no early syn flag", int'(status[2]), 0);
                    wait_cyc(T + 20);
                    chk("R2 ref flag", int'(status[1]), exp_ref);
                    chk("R3 syn flag", int'(status[2]), exp_syn);
                    chk("R9 spare bits", int'(status & 8'hF9), 0);
                    chk("R6 valid", int'(clocks_valid), exp_valid);
                    chk("R7 reset_req", int'(reset_req), exp_rr);

                    ref_en = 1'b1; syn_en = 1'b1;
                    if (lp == 2) lock_in = 1'b1;
                    wait_cyc(40);
                    chk("R4 ref flag kept", int'(status[1]), exp_ref);
                    chk("R4 syn flag kept", int'(status[2]), exp_syn);
                    chk("R10 valid after relock", int'(clocks_valid), exp_valid);
                    chk("R10 reset_req after relock", int'(reset_req), exp_rr);
                end
            end
        end
        summary();
    end
endmodule